// File: doc/BRIEF.md
# Cursor Key Capture with Control Code Injector

This block sits between four cursor-direction keys and a control processor. That processor looks at the keyboard only during the vertical retrace interval. Each key press is synchronised into the clock domain and then caught in a set/hold latch. The latch keeps the press until retrace processing has consumed it, so even a very short tap reaches the processor.

Latches accept new presses only while the active display is being scanned. Their contents are frozen for the whole retrace processing window, so the processor sees stable values. When that window ends, a latch is released only if its key has been let go.

Two further functions share the block. The first turns two select lines into one of three ASCII control characters on a byte-wide data output that has an enable flag. The second samples twelve active-low mode switches and presents them as synchronised active-high levels.

Top module: `curkey_front`

## Requirements
- R1: During and right after reset, `key_held`, `code_out`, `code_oe` and `mode_lvl` are all zero.
- R2: A key held high on `key_raw` while `in_scan`=1 and `retrace_busy`=0 sets its bit of `key_held` on the third rising edge after the key changes: two synchroniser stages, then the latch. Bit 0=up, 1=down, 2=left, 3=right.
- R3: Once set, a `key_held` bit stays set after the key is released, until a retrace end (R5) occurs.
- R4: While `retrace_busy`=1, `key_held` does not change, whatever `key_raw` and `in_scan` do.
- R5: A retrace end is a rising edge at which `retrace_busy` is 0 and was 1 at the previous edge. At that edge, each bit whose synchronised key is low clears, and each bit whose key is still pressed stays set.
- R6: When `in_scan`=0 and `retrace_busy`=0, key presses set no `key_held` bit.
- R7: On the edge after `sel_a1`/`sel_a2` are sampled, `code_oe`=1 and `code_out` is 0x0D for `sel_a1` alone, 0x20 for `sel_a2` alone, and 0x0A for both.
- R8: When both select lines are low, `code_oe`=0 and `code_out`=0x00 from the next edge.
- R9: `mode_lvl[i]` equals the inverse of `mode_sw_n[i]`, two rising edges after the input changes.
- R10: Each key latch acts independently. A one-cycle pulse on one key sets only that key's bit and leaves the other bits as they were.
- R11: At a retrace end with `in_scan`=1, a key that is pressed sets its bit at that same edge. The clear and the capture combine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_raw | input | 4 | Asynchronous cursor key levels, active high |
| in_scan | input | 1 | High during active display scan |
| retrace_busy | input | 1 | High while the control processor runs its retrace cycle |
| sel_a1 | input | 1 | Code select line 1 |
| sel_a2 | input | 1 | Code select line 2 |
| mode_sw_n | input | 12 | Active-low mode switch levels |
| key_held | output | 4 | Latched key presses |
| code_out | output | 8 | Injected control character |
| code_oe | output | 1 | Code output valid / drive enable |
| mode_lvl | output | 12 | Synchronised active-high mode levels |

## Verification
Releasing latches at the end of retrace and capturing a new press during scan can happen on the same clock edge. The bench provokes this by holding a key down through a frozen retrace window with `in_scan` high, then dropping `retrace_busy`. The key's bit must read set at the very next sample, not one edge later and not cleared. The opposite case is also checked: a bit whose key was released during retrace must clear at the end edge while a neighbouring bit whose key is still pressed stays set.

// File: rtl/curkey_pkg.sv
// Shared constants and helpers for the cursor key capture block.
// Assumes ASCII encoding for injected control characters.
package curkey_pkg;
    localparam int NUM_KEYS  = 4;
    localparam int NUM_MODES = 12;
    localparam int CODE_W    = 8;

    typedef enum logic [1:0] {
        KEY_UP    = 2'd0,
        KEY_DOWN  = 2'd1,
        KEY_LEFT  = 2'd2,
        KEY_RIGHT = 2'd3
    } key_idx_e;

    localparam logic [CODE_W-1:0] CHR_CR    = 8'h0D;
    localparam logic [CODE_W-1:0] CHR_SPACE = 8'h20;
    localparam logic [CODE_W-1:0] CHR_LF    = 8'h0A;
    localparam logic [CODE_W-1:0] CHR_NONE  = 8'h00;

    // Map the two select lines to a control character.
    function automatic logic [CODE_W-1:0] pick_code(input logic s1, input logic s2);
        logic [CODE_W-1:0] c;
        unique case ({s2, s1})
            2'b01:   c = CHR_CR;
            2'b10:   c = CHR_SPACE;
            2'b11:   c = CHR_LF;
            default: c = CHR_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/curkey_sync.sv
// Two-stage synchroniser for a vector of asynchronous levels.
// Assumes each bit is a slow level; no multi-bit coherence is promised.
// RST_VAL sets the value both stages take in reset.
module curkey_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/curkey_latch_bank.sv
// Set/hold latches for the synchronised cursor keys.
// A bit sets during active scan, freezes while retrace processing runs,
// and on the edge that ends retrace keeps only bits whose key is still down.
// Assumes retrace_busy and in_scan are already in the clock domain.
module curkey_latch_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] key_sync,
    input  logic         in_scan,
    input  logic         retrace_busy,
    output logic [N-1:0] held
);
    logic retrace_q;
    logic end_edge;
    logic set_en;

    // Remember whether retrace processing ran on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) retrace_q <= 1'b0;
        else        retrace_q <= retrace_busy;
    end

    assign end_edge = retrace_q & ~retrace_busy;
    assign set_en   = in_scan & ~retrace_busy;

    for (genvar k = 0; k < N; k++) begin : g_key
        // One latch per key: freeze, clear-at-end, then set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[k] <= 1'b0;
            end else if (retrace_busy) begin
                held[k] <= held[k];
            end else begin
                held[k] <= (end_edge ? (held[k] & key_sync[k]) : held[k])
                         | (set_en & key_sync[k]);
            end
        end
    end
endmodule

// File: rtl/curkey_code_inject.sv
// Registered control-character injector driven by two select lines.
// Output enable is high whenever either select is high; the data is
// forced to zero when disabled so no stale byte is presented.
module curkey_code_inject
    import curkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a1,
    input  logic              sel_a2,
    output logic [CODE_W-1:0] code_out,
    output logic              code_oe
);
    // Register the selected character and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= CHR_NONE;
            code_oe  <= 1'b0;
        end else begin
            code_out <= pick_code(sel_a1, sel_a2);
            code_oe  <= sel_a1 | sel_a2;
        end
    end
endmodule

// File: rtl/curkey_front.sv
// Top: cursor key capture, control character injector and mode switch
// sampling. Keys are active high; mode switches are active low with
// pull-ups, so reset puts the synchroniser in the released state.
module curkey_front
    import curkey_pkg::*;
#(
    parameter int NK = NUM_KEYS,
    parameter int NM = NUM_MODES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NK-1:0]     key_raw,
    input  logic              in_scan,
    input  logic              retrace_busy,
    input  logic              sel_a1,
    input  logic              sel_a2,
    input  logic [NM-1:0]     mode_sw_n,
    output logic [NK-1:0]     key_held,
    output logic [CODE_W-1:0] code_out,
    output logic              code_oe,
    output logic [NM-1:0]     mode_lvl
);
    localparam logic [NM-1:0] MODE_IDLE = '1;

    logic [NK-1:0] key_sync;
    logic [NM-1:0] mode_sync_n;

    curkey_sync #(.W(NK), .RST_VAL('0)) u_key_sync (
        .clk(clk), .rst_n(rst_n), .d_async(key_raw), .q_sync(key_sync)
    );

    curkey_latch_bank #(.N(NK)) u_latches (
        .clk(clk), .rst_n(rst_n), .key_sync(key_sync),
        .in_scan(in_scan), .retrace_busy(retrace_busy), .held(key_held)
    );

    curkey_code_inject u_inject (
        .clk(clk), .rst_n(rst_n), .sel_a1(sel_a1), .sel_a2(sel_a2),
        .code_out(code_out), .code_oe(code_oe)
    );

    curkey_sync #(.W(NM), .RST_VAL(MODE_IDLE)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d_async(mode_sw_n), .q_sync(mode_sync_n)
    );

    // Present mode switches as active-high levels.
    assign mode_lvl = ~mode_sync_n;
endmodule

// File: rtl/curkey_front_chk.sv
// Checker for curkey_front, bound to every instance of the top.
module curkey_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_scan,
    input logic        retrace_busy,
    input logic        sel_a1,
    input logic        sel_a2,
    input logic [11:0] mode_sw_n,
    input logic [3:0]  key_held,
    input logic [7:0]  code_out,
    input logic        code_oe,
    input logic [11:0] mode_lvl
);
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retrace_busy |=> key_held == $past(key_held));

    p_no_idle_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_scan && !retrace_busy) |=> (key_held & ~$past(key_held)) == 4'b0);

    p_end_only_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(retrace_busy) && !retrace_busy && !in_scan)
        |=> (key_held & ~$past(key_held)) == 4'b0);

    p_code_cr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a1 && !sel_a2) |=> (code_oe && code_out == 8'h0D));

    p_code_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a1 && sel_a2) |=> (code_oe && code_out == 8'h20));

    p_code_lf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a1 && sel_a2) |=> (code_oe && code_out == 8'h0A));

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a1 && !sel_a2) |=> (!code_oe && code_out == 8'h00));

    p_mode_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> mode_lvl == ~$past(mode_sw_n, 2));
endmodule

bind curkey_front curkey_front_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_scan(in_scan), .retrace_busy(retrace_busy),
    .sel_a1(sel_a1), .sel_a2(sel_a2), .mode_sw_n(mode_sw_n),
    .key_held(key_held), .code_out(code_out), .code_oe(code_oe),
    .mode_lvl(mode_lvl)
);

// File: tb/curkey_front_tb_top.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops
// and compares them shortly after each falling edge.
module curkey_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  key_raw = '0;
    logic        in_scan = 1'b0;
    logic        retrace_busy = 1'b0;
    logic        sel_a1 = 1'b0;
    logic        sel_a2 = 1'b0;
    logic [11:0] mode_sw_n = 12'hFFF;
    logic [3:0]  key_held;
    logic [7:0]  code_out;
    logic        code_oe;
    logic [11:0] mode_lvl;

    typedef struct {
        string       req;
        int          kind;
        logic [11:0] exp;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    curkey_front dut_i (
        .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .in_scan(in_scan),
        .retrace_busy(retrace_busy), .sel_a1(sel_a1), .sel_a2(sel_a2),
        .mode_sw_n(mode_sw_n), .key_held(key_held), .code_out(code_out),
        .code_oe(code_oe), .mode_lvl(mode_lvl)
    );

    // kind 0: key_held, 1: {code_oe, code_out}, 2: mode_lvl
    task automatic expect_item(input string req, input int kind, input logic [11:0] v);
        item_t it;
        it.req = req; it.kind = kind; it.exp = v;
        q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every queued item against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [11:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = {8'h0, key_held};
                    1:       act = {3'b0, code_oe, code_out};
                    default: act = mode_lvl;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        expect_item("R1", 0, 12'h000);
        expect_item("R1", 1, 12'h000);
        expect_item("R1", 2, 12'h000);
        step(1);

        // R2: press up during scan, latency of three edges.
        in_scan = 1'b1;
        key_raw = 4'b0001;
        step(2);
        expect_item("R2 latency", 0, 12'h000);
        step(1);
        expect_item("R2", 0, 12'h001);

        // R3: release keeps the bit.
        key_raw = 4'b0000;
        step(5);
        expect_item("R3", 0, 12'h001);

        // R10: one-cycle pulse on left sets only that bit.
        key_raw = 4'b0100;
        step(1);
        key_raw = 4'b0000;
        step(4);
        expect_item("R10", 0, 12'h005);

        // R4: frozen during retrace even with scan high.
        retrace_busy = 1'b1;
        key_raw = 4'b1001;
        step(4);
        expect_item("R4", 0, 12'h005);
        key_raw = 4'b0001;
        step(3);
        expect_item("R4", 0, 12'h005);

        // R5: end of retrace clears left (released), keeps up (still down).
        in_scan = 1'b0;
        retrace_busy = 1'b0;
        step(1);
        expect_item("R5", 0, 12'h001);
        key_raw = 4'b0000;
        step(3);
        expect_item("R3 after end", 0, 12'h001);
        retrace_busy = 1'b1;
        step(1);
        retrace_busy = 1'b0;
        step(1);
        expect_item("R5 release", 0, 12'h000);

        // R6: no capture outside scan and retrace.
        key_raw = 4'b0010;
        step(4);
        key_raw = 4'b0000;
        step(3);
        expect_item("R6", 0, 12'h000);

        // R11: clear and capture on the same end edge.
        retrace_busy = 1'b1;
        in_scan = 1'b1;
        key_raw = 4'b0010;
        step(4);
        expect_item("R11 frozen", 0, 12'h000);
        retrace_busy = 1'b0;
        step(1);
        expect_item("R11", 0, 12'h002);
        key_raw = 4'b0000;

        // R7 / R8: code injector.
        sel_a1 = 1'b1; sel_a2 = 1'b0;
        step(1);
        expect_item("R7 CR", 1, 12'h10D);
        sel_a1 = 1'b0; sel_a2 = 1'b1;
        step(1);
        expect_item("R7 SP", 1, 12'h120);
        sel_a1 = 1'b1; sel_a2 = 1'b1;
        step(1);
        expect_item("R7 LF", 1, 12'h10A);
        sel_a1 = 1'b0; sel_a2 = 1'b0;
        step(1);
        expect_item("R8", 1, 12'h000);

        // R9: mode switches, inverted after two edges.
        mode_sw_n = 12'h5A3;
        step(1);
        expect_item("R9 latency", 2, 12'h000);
        step(1);
        expect_item("R9", 2, 12'hA5C);
        mode_sw_n = 12'hFFF;
        step(2);
        expect_item("R9 idle", 2, 12'h000);

        step(2);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule